// File: doc/BRIEF.md
# Six-Channel TDM Audio Serializer

This block turns a set of six 24-bit audio samples into one time-division-multiplexed serial stream. It is the clock master of that stream. From the system clock it generates a bit clock, a frame sync and one serial data line. A frame is 256 bit-clock periods long, one frame per audio sample period. The frame is cut into 32-period slots. Slots 0 through 5 carry channels 0 through 5 in ascending order, and the last two slots stay idle. Inside a slot, the most significant bit of the sample follows the slot boundary by one bit-clock period, in the same way as the familiar two-channel serial audio format. The 24 sample bits come next, MSB first, and the rest of the slot is driven low.

Upstream logic offers a full set of six samples through a valid/ready handshake. An accepted set waits in a holding register. It moves into the output bank together, all six channels at once, at the next frame boundary. If no new set has arrived by a boundary, the bank keeps its contents and the previous samples go out again. The frame sync and the data line only ever change in the system cycle in which the bit clock falls, so a receiver can capture them on the rising bit-clock edge.

Top module: `tdm6_serializer`

## Requirements
- R1: The bit clock runs at a 50% duty cycle with a period of 2×HALF_DIV system clocks (default 4). One frame is exactly 256 bit-clock periods, numbered 0 to 255.
- R2: During periods 0 to 127 of a frame the frame sync is low. During periods 128 to 255 it is high.
- R3: Slot s covers periods 32s to 32s+31. For k = 0 to 23, period 32s+1+k carries bit 23−k of that slot's sample, so the MSB comes first.
- R4: Slot s (0 to 5) carries channel s, the sample taken from `smp_data[24s+23:24s]`.
- R5: The data line is low in the first period of each slot and in offsets 25 to 31 of each slot. It is also low for all of periods 192 to 255.
- R6: The frame sync and the data line change only in the system cycle in which the bit clock goes from high to low.
- R7: `smp_ready` is high while the holding register is empty. A set is accepted on a clock edge where `smp_valid` and `smp_ready` are both high, and `smp_ready` is low in the cycle after an acceptance.
- R8: A held set moves into the output bank on the bit-clock fall that begins period 0. It is used for that entire frame, and `smp_ready` goes high again in the next cycle.
- R9: When no set is held at a frame boundary, the output bank keeps its contents and the next frame repeats the previous samples.
- R10: During and right after reset, the bit clock, frame sync and data line are low and `smp_ready` is high. Period 0 of the first frame starts at reset release, and that first frame carries all-zero samples.
- R11: A set accepted in the same cycle as a frame boundary is not used for the frame that starts there. It goes out from the frame after that one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A full six-channel sample set is offered |
| smp_ready | output | 1 | Holding register is empty and can take a set |
| smp_data | input | SLOTS×SAMPLE_W (144) | Six samples, channel s in bits [24s+23:24s] |
| tdm_bclk | output | 1 | Generated bit clock |
| tdm_fsync | output | 1 | Frame sync, low for the first half of the frame |
| tdm_sdata | output | 1 | Serial TDM data |

## Verification
Two events can land on the same system clock edge. One is the acceptance of a new sample set through the handshake. The other is the frame-boundary latch, which copies the held set into the output bank. The bench waits for the last system cycle before the bit clock falls into period 0 and raises `smp_valid` for exactly that edge. Every later frame is then decoded bit by bit from the data line: the frame that starts at that boundary must still carry the old set, and the new set must appear only one frame later. A behavioural reference model is compared against all four outputs on every clock, so the ready flag is also checked in the cycle of the collision.

// File: rtl/tdm6_pkg.sv
package tdm6_pkg;

  // Strobe that announces the bit-clock transition taken on the next edge.
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } bclk_edge_e;

endpackage

// File: rtl/tdm6_clkgen.sv
module tdm6_clkgen
  import tdm6_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  output logic       bclk,
  output bclk_edge_e edge_nxt
);

  localparam int DIV  = 2 * HALF_DIV;
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF_DIV - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase;

  always_comb begin
    edge_nxt = EDGE_NONE;
    if (phase == PH_FALL)      edge_nxt = EDGE_FALL;
    else if (phase == PH_RISE) edge_nxt = EDGE_RISE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      bclk  <= 1'b0;
    end else begin
      phase <= (phase == PH_FALL) ? '0 : phase + 1'b1;
      if (edge_nxt == EDGE_FALL)      bclk <= 1'b0;
      else if (edge_nxt == EDGE_RISE) bclk <= 1'b1;
    end
  end

  // R1: a rise is only announced while the clock is low, a fall only while high
  assert_rise_from_low_R1: assert property (@(posedge clk) disable iff (rst)
    (edge_nxt == EDGE_RISE) |-> !bclk);
  assert_fall_from_high_R1: assert property (@(posedge clk) disable iff (rst)
    (edge_nxt == EDGE_FALL) |-> bclk);

endmodule

// File: rtl/tdm6_bitpos.sv
module tdm6_bitpos #(
  parameter int FRAME_BITS = 256,
  parameter int IDX_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] bit_idx,
  output logic [IDX_W-1:0] next_idx,
  output logic             wrap
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  assign next_idx = (bit_idx == LAST_IDX) ? '0 : bit_idx + 1'b1;
  assign wrap     = adv && (bit_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst)      bit_idx <= '0;
    else if (adv) bit_idx <= next_idx;
  end

  // R1: the frame closes after its last period and restarts at zero
  assert_frame_restart_R1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (bit_idx == '0));
  assert_period_step_R1: assert property (@(posedge clk) disable iff (rst)
    (adv && !wrap) |=> (bit_idx == IDX_W'($past(bit_idx) + 1'b1)));
  assert_hold_between_R1: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(bit_idx));

endmodule

// File: rtl/tdm6_bank.sv
module tdm6_bank #(
  parameter int SLOTS    = 6,
  parameter int SAMPLE_W = 24,
  parameter int SLOT_IW  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SLOTS*SAMPLE_W-1:0] in_data,
  input  logic                      load,
  input  logic [SLOT_IW-1:0]        rd_slot,
  output logic [SAMPLE_W-1:0]       rd_word
);

  logic [SAMPLE_W-1:0] hold_q [SLOTS];
  logic [SAMPLE_W-1:0] live_q [SLOTS];
  logic                hold_empty;
  logic                accept;

  assign accept   = in_valid && hold_empty;
  assign in_ready = hold_empty;
  assign rd_word  = live_q[rd_slot];

  always_ff @(posedge clk) begin
    if (rst)         hold_empty <= 1'b1;
    else if (accept) hold_empty <= 1'b0;
    else if (load)   hold_empty <= 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (accept) hold_q[g] <= in_data[g*SAMPLE_W +: SAMPLE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)                      live_q[g] <= '0;
      else if (load && !hold_empty) live_q[g] <= hold_q[g];
    end
  end

  // R7: a taken set closes the handshake in the following cycle
  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R9: a held set stays parked until a frame boundary
  assert_hold_until_frame_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !load) |=> !in_ready);
  // R8: a boundary empties the holding register
  assert_refill_after_load_R8: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && load) |=> in_ready);

endmodule

// File: rtl/tdm6_serializer.sv
module tdm6_serializer
  import tdm6_pkg::*;
#(
  parameter int SLOTS      = 6,
  parameter int SAMPLE_W   = 24,
  parameter int SLOT_W     = 32,
  parameter int FRAME_BITS = 256,
  parameter int HALF_DIV   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      smp_valid,
  output logic                      smp_ready,
  input  logic [SLOTS*SAMPLE_W-1:0] smp_data,
  output logic                      tdm_bclk,
  output logic                      tdm_fsync,
  output logic                      tdm_sdata
);

  localparam int IDX_W   = $clog2(FRAME_BITS);
  localparam int POS_W   = $clog2(SLOT_W);
  localparam int SNUM_W  = IDX_W - POS_W;
  localparam int SLOT_IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int SEL_W   = $clog2(SAMPLE_W);

  localparam logic [IDX_W-1:0]  SYNC_HIGH_FROM = IDX_W'(FRAME_BITS / 2);
  localparam logic [IDX_W-1:0]  IDLE_FROM      = IDX_W'(SLOTS * SLOT_W);
  localparam logic [POS_W-1:0]  LAST_DATA_POS  = POS_W'(SAMPLE_W);
  localparam logic [SNUM_W-1:0] SLOT_LIMIT     = SNUM_W'(SLOTS);

  bclk_edge_e            edge_nxt;
  logic                  adv;
  logic [IDX_W-1:0]      bit_idx;
  logic [IDX_W-1:0]      next_idx;
  logic                  frame_wrap;
  logic [SNUM_W-1:0]     slot_num;
  logic [POS_W-1:0]      slot_pos;
  logic                  in_slot;
  logic                  in_word;
  logic [SLOT_IW-1:0]    rd_slot;
  logic [SAMPLE_W-1:0]   rd_word;
  logic [SEL_W-1:0]      bit_sel;
  logic                  next_bit;

  tdm6_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .bclk     (tdm_bclk),
    .edge_nxt (edge_nxt)
  );

  assign adv = (edge_nxt == EDGE_FALL);

  tdm6_bitpos #(.FRAME_BITS(FRAME_BITS), .IDX_W(IDX_W)) u_bitpos (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .bit_idx  (bit_idx),
    .next_idx (next_idx),
    .wrap     (frame_wrap)
  );

  tdm6_bank #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .SLOT_IW(SLOT_IW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .in_valid (smp_valid),
    .in_ready (smp_ready),
    .in_data  (smp_data),
    .load     (frame_wrap),
    .rd_slot  (rd_slot),
    .rd_word  (rd_word)
  );

  // Position of the period about to start, split into slot and offset.
  assign slot_num = next_idx[IDX_W-1:POS_W];
  assign slot_pos = next_idx[POS_W-1:0];
  assign in_slot  = (slot_num < SLOT_LIMIT);
  assign in_word  = (slot_pos != '0) && (slot_pos <= LAST_DATA_POS);
  assign rd_slot  = in_slot ? slot_num[SLOT_IW-1:0] : '0;
  assign bit_sel  = SEL_W'(LAST_DATA_POS - slot_pos);
  assign next_bit = in_slot && in_word && rd_word[bit_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      tdm_fsync <= 1'b0;
      tdm_sdata <= 1'b0;
    end else if (adv) begin
      tdm_fsync <= (next_idx >= SYNC_HIGH_FROM);
      tdm_sdata <= next_bit;
    end
  end

  // R6: line outputs move only together with a falling bit clock
  assert_fsync_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (edge_nxt != EDGE_FALL) |=> $stable(tdm_fsync));
  assert_sdata_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (edge_nxt != EDGE_FALL) |=> $stable(tdm_sdata));
  // R2: sync level follows the half of the frame in progress
  assert_fsync_half_R2: assert property (@(posedge clk) disable iff (rst)
    tdm_fsync == (bit_idx >= SYNC_HIGH_FROM));
  // R5: tail of the frame and slot-start periods are quiet
  assert_idle_tail_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_idx >= IDLE_FROM) |-> !tdm_sdata);
  assert_slot_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_idx[POS_W-1:0] == '0) |-> !tdm_sdata);

endmodule

// File: tb/tb_tdm6_serializer.sv
module tb_tdm6_serializer;

  localparam int HALF  = 2;
  localparam int DIV   = 2 * HALF;
  localparam int FRAME = 256;
  localparam int SLOTS = 6;
  localparam int SW    = 24;
  localparam int SLW   = 32;
  localparam int DW    = SLOTS * SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          smp_ready;
  logic          tdm_bclk;
  logic          tdm_fsync;
  logic          tdm_sdata;

  always #5 clk = ~clk;

  tdm6_serializer #(
    .SLOTS(SLOTS), .SAMPLE_W(SW), .SLOT_W(SLW), .FRAME_BITS(FRAME), .HALF_DIV(HALF)
  ) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .tdm_bclk(tdm_bclk), .tdm_fsync(tdm_fsync), .tdm_sdata(tdm_sdata)
  );

  int checks = 0;
  int errors = 0;
  int fnum   = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_ph, m_bcnt;
  logic        m_bclk, m_fs, m_sd, m_full;
  logic [SW-1:0] m_act  [SLOTS];
  logic [SW-1:0] m_pend [SLOTS];

  function automatic logic m_bit(input int b);
    int s = b / SLW;
    int p = b % SLW;
    if (s < SLOTS && p >= 1 && p <= SW) return m_act[s][SW-p];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    bit fall, rise, acc, fstart;
    if (rst) begin
      m_ph = 0; m_bcnt = 0; m_bclk = 0; m_fs = 0; m_sd = 0; m_full = 0;
      for (int i = 0; i < SLOTS; i++) begin m_act[i] = '0; m_pend[i] = '0; end
    end else begin
      fall   = (m_ph == DIV - 1);
      rise   = (m_ph == HALF - 1);
      acc    = smp_valid && !m_full;
      fstart = fall && (m_bcnt == FRAME - 1);
      if (fstart && m_full) begin
        for (int i = 0; i < SLOTS; i++) m_act[i] = m_pend[i];
        m_full = 0;
      end
      if (acc) begin
        for (int i = 0; i < SLOTS; i++) m_pend[i] = smp_data[i*SW +: SW];
        m_full = 1;
      end
      if (fall) begin
        m_bcnt = (m_bcnt + 1) % FRAME;
        m_bclk = 0;
        m_fs   = (m_bcnt >= FRAME / 2);
        m_sd   = m_bit(m_bcnt);
      end
      if (rise) m_bclk = 1;
      m_ph = (m_ph + 1) % DIV;
    end
  end

  // ---------------- per-cycle comparison and frame capture ----------------
  logic cap  [FRAME];
  logic last [FRAME];
  logic p_bclk = 1'b0, p_fs = 1'b0, p_sd = 1'b0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tdm_bclk  == m_bclk,  "R1", "bit clock",  tdm_bclk,  m_bclk);
      chk(tdm_fsync == m_fs,    "R2", "frame sync", tdm_fsync, m_fs);
      chk(tdm_sdata == m_sd,    "R3", "serial data", tdm_sdata, m_sd);
      chk(smp_ready == !m_full, "R7", "ready",      smp_ready, !m_full);
      if (tdm_fsync != p_fs || tdm_sdata != p_sd)
        chk(p_bclk && !tdm_bclk, "R6", "line change without falling bit clock",
            tdm_bclk, 0);
      if (m_bclk && m_ph == HALF) begin
        cap[m_bcnt] = tdm_sdata;
        if (m_bcnt == FRAME - 1) begin
          last = cap;
          fnum++;
        end
      end
    end
    p_bclk = tdm_bclk; p_fs = tdm_fsync; p_sd = tdm_sdata;
  end

  // Decode a captured frame against an expected sample set.
  task automatic check_frame(input logic [DW-1:0] exp, input string req);
    logic [SW-1:0] w;
    int stray = 0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int k = 0; k < SW; k++) w[SW-1-k] = last[s*SLW + 1 + k];
      chk(w == exp[s*SW +: SW], req, $sformatf("slot %0d word (R3 R4)", s),
          w, exp[s*SW +: SW]);
    end
    for (int b = 0; b < FRAME; b++) begin
      int p = b % SLW;
      if ((b / SLW) >= SLOTS || p == 0 || p > SW) if (last[b]) stray++;
    end
    chk(stray == 0, "R5", "high bits outside sample fields", stray, 0);
  endtask

  function automatic logic [DW-1:0] make_set(input logic [7:0] seed);
    logic [DW-1:0] v;
    for (int s = 0; s < SLOTS; s++)
      v[s*SW +: SW] = {seed ^ 8'(s * 37), 8'(s), ~seed};
    return v;
  endfunction

  task automatic send(input logic [DW-1:0] v);
    @(negedge clk);
    smp_data  = v;
    smp_valid = 1'b1;
    while (smp_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    chk(smp_ready == 1'b0, "R7", "ready after acceptance", smp_ready, 0);
  endtask

  logic [DW-1:0] set_a, set_b, set_c;

  initial begin
    set_a = make_set(8'hA5);
    set_b = make_set(8'h3C);
    for (int s = 0; s < SLOTS; s++)
      set_c[s*SW +: SW] = (s % 2 == 0) ? 24'hFFFFFF : 24'h800001;

    repeat (4) @(negedge clk);
    chk(tdm_bclk  == 1'b0, "R10", "bit clock in reset",  tdm_bclk,  0);
    chk(tdm_fsync == 1'b0, "R10", "frame sync in reset", tdm_fsync, 0);
    chk(tdm_sdata == 1'b0, "R10", "data in reset",       tdm_sdata, 0);
    chk(smp_ready == 1'b1, "R10", "ready in reset",      smp_ready, 1);
    rst = 1'b0;

    send(set_a);
    wait (fnum == 1); check_frame('0,    "R10");
    wait (fnum == 2); check_frame(set_a, "R8");
    wait (fnum == 3); check_frame(set_a, "R9");
    repeat (100) @(negedge clk);
    send(set_b);
    wait (fnum == 4); check_frame(set_a, "R9");
    wait (fnum == 5); check_frame(set_b, "R8");

    // R11: offer a set exactly on the frame-boundary edge
    repeat (20) @(negedge clk);
    while (!(m_ph == DIV - 1 && m_bcnt == FRAME - 1)) @(negedge clk);
    chk(smp_ready == 1'b1, "R11", "ready before boundary", smp_ready, 1);
    smp_data  = set_c;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(smp_ready == 1'b0, "R11", "set taken at boundary", smp_ready, 0);
    wait (fnum == 7); check_frame(set_b, "R11");
    wait (fnum == 8); check_frame(set_c, "R8");

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    finish_run();
  end

endmodule